// File: doc/BRIEF.md
# Push-Button Register File Exerciser

This block is a bench-top front end for a tiny register file holding four 4-bit entries with two independent read ports. Three push buttons drive it. Each button passes through a synchronizer and a stable-level filter, producing exactly one single-cycle step strobe for each clean press.

The write button steps a modulo-4 counter. That counter is both the write address and the selector of the value written. As a result, a full round of four presses loads the registers with a fixed counting pattern.

The two read buttons each step their own address counter, one per read port. The selected entries appear on the port data outputs. Each port value is also decoded to an active-low seven-segment code. A select input routes one of the two segment codes to a single shared display output.

Everything runs on one system clock with clock enables and a synchronous reset. The register array is read combinationally from the read addresses.

Top module: `pb_regfile_exerciser`

## Requirements
- R1: While `rst` is high at a clock edge, all three counters and all four registers clear to zero. After reset, `wrAddr`, `rdAddrA` and `rdAddrB` read 0, both port outputs read 0, and every segment output reads 7'b0000001.
- R2: A raw button level counts as changed only after the synchronized level has differed from the accepted level for `STABLE_LEN` consecutive clock cycles. Bursts made of shorter levels step no counter.
- R3: One accepted press gives exactly one step, however long the button is held. Releasing the button gives no step.
- R4: On a write step, the register addressed by the current write count is loaded with count+1 (address 0 gets 4'b0001, 1 gets 4'b0010, 2 gets 4'b0011, 3 gets 4'b0100). The write count then advances by one, wrapping from 3 to 0. Without a write step, the count holds.
- R5: The port-A read button advances only `rdAddrA`, and the port-B button advances only `rdAddrB`. Each advances by one modulo 4, so successive presses after reset show 01, 10, 11, 00 and then repeat.
- R6: `portA` equals the register at `rdAddrA`, and `portB` equals the register at `rdAddrB`. These are combinational reads. A write is visible on the cycle after its step.
- R7: `segA` and `segB` encode their port value active-low, with segment a in bit 6 and segment g in bit 0. The codes are 0→0000001, 1→1001111, 2→0010010, 3→0000110 and 4→1001100. Values 5 to F use the usual hexadecimal glyphs, and 8 gives 0000000.
- R8: `segDisp` carries `segA` when `dispSel` is 0 and `segB` when `dispSel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btnWrite | input | 1 | Raw write button, pressed = 1 |
| btnReadA | input | 1 | Raw port-A read button, pressed = 1 |
| btnReadB | input | 1 | Raw port-B read button, pressed = 1 |
| dispSel | input | 1 | Shared display source: 0 = port A, 1 = port B |
| wrAddr | output | 2 | Current write count / write address |
| rdAddrA | output | 2 | Port-A read address |
| rdAddrB | output | 2 | Port-B read address |
| portA | output | 4 | Register value at `rdAddrA` |
| portB | output | 4 | Register value at `rdAddrB` |
| segA | output | 7 | Active-low segments for `portA`, a in bit 6 |
| segB | output | 7 | Active-low segments for `portB`, a in bit 6 |
| segDisp | output | 7 | Selected segment code for the shared display |

## Verification
The bench builds the block with `STABLE_LEN` = 4 and `SYNC_STAGES` = 2. With these values an accepted press settles within about ten cycles. That short window lets the bench drive bounce bursts of 2-cycle levels, which must be rejected, and holds of 60 cycles, which must give only one step, all within a few hundred cycles.

The small filter length also makes a full wrap of every counter cheap. The bench can therefore check the whole write pattern, the independent read sequences of both ports and both settings of the display select.

// File: rtl/pb_exer_pkg.sv
package pb_exer_pkg;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 4;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int SEG_W    = 7;
  localparam int NUM_BTNS = 3;

  typedef struct packed {
    logic wrStep;
    logic rdAStep;
    logic rdBStep;
  } stepStrobes_t;
endpackage

// File: rtl/pb_debounce.sv
module pb_debounce #(
  parameter int STABLE_LEN  = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btnRaw,
  output logic pressPulse
);
  localparam int CNT_W = $clog2(STABLE_LEN + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLevel;
  logic                   cleanLevel;
  logic [CNT_W-1:0]       stableCnt;

  always_ff @(posedge clk) begin
    if (rst) syncChain <= '0;
    else     syncChain <= {syncChain[SYNC_STAGES-2:0], btnRaw};
  end
  assign syncLevel = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cleanLevel <= 1'b0;
      stableCnt  <= '0;
      pressPulse <= 1'b0;
    end else begin
      pressPulse <= 1'b0;
      if (syncLevel == cleanLevel) begin
        stableCnt <= '0;
      end else if (stableCnt == CNT_W'(STABLE_LEN - 1)) begin
        cleanLevel <= syncLevel;
        stableCnt  <= '0;
        pressPulse <= syncLevel;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end

  // R3: a step strobe never lasts more than one cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    pressPulse |=> !pressPulse);
  // R2: a step follows only a synchronized pressed level
  assert_pulse_from_level_R2: assert property (@(posedge clk) disable iff (rst)
    pressPulse |-> $past(syncLevel));
  // R2: the filter counter stays below its limit
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    stableCnt < CNT_W'(STABLE_LEN));
endmodule

// File: rtl/pb_hex_seg.sv
module pb_hex_seg (
  input  logic [3:0] nibble,
  output logic [6:0] segN
);
  always_comb begin
    unique case (nibble)
      4'h0: segN = 7'b0000001;
      4'h1: segN = 7'b1001111;
      4'h2: segN = 7'b0010010;
      4'h3: segN = 7'b0000110;
      4'h4: segN = 7'b1001100;
      4'h5: segN = 7'b0100100;
      4'h6: segN = 7'b0100000;
      4'h7: segN = 7'b0001111;
      4'h8: segN = 7'b0000000;
      4'h9: segN = 7'b0000100;
      4'hA: segN = 7'b0001000;
      4'hB: segN = 7'b1100000;
      4'hC: segN = 7'b0110001;
      4'hD: segN = 7'b1000010;
      4'hE: segN = 7'b0110000;
      default: segN = 7'b0111000;
    endcase
  end
endmodule

// File: rtl/pb_step_control.sv
module pb_step_control
  import pb_exer_pkg::*;
#(
  parameter int STABLE_LEN  = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         btnWrite,
  input  logic         btnReadA,
  input  logic         btnReadB,
  output stepStrobes_t strobes
);
  logic [NUM_BTNS-1:0] rawVec;
  logic [NUM_BTNS-1:0] pulseVec;

  assign rawVec = {btnReadB, btnReadA, btnWrite};

  for (genvar g = 0; g < NUM_BTNS; g++) begin : g_deb
    pb_debounce #(
      .STABLE_LEN (STABLE_LEN),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_deb (
      .clk       (clk),
      .rst       (rst),
      .btnRaw    (rawVec[g]),
      .pressPulse(pulseVec[g])
    );
  end

  assign strobes.wrStep  = pulseVec[0];
  assign strobes.rdAStep = pulseVec[1];
  assign strobes.rdBStep = pulseVec[2];
endmodule

// File: rtl/pb_regfile_datapath.sv
module pb_regfile_datapath
  import pb_exer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  stepStrobes_t      strobes,
  input  logic              dispSel,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddrA,
  output logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] portA,
  output logic [DATA_W-1:0] portB,
  output logic [SEG_W-1:0]  segA,
  output logic [SEG_W-1:0]  segB,
  output logic [SEG_W-1:0]  segDisp
);
  logic [ADDR_W-1:0] wrCnt;
  logic [ADDR_W-1:0] rdCntA;
  logic [ADDR_W-1:0] rdCntB;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] portVal [2];
  logic [SEG_W-1:0]  segVal [2];

  // write value picked from the write count: entry k receives k+1
  always_comb wrData = DATA_W'(wrCnt) + DATA_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrCnt  <= '0;
      rdCntA <= '0;
      rdCntB <= '0;
    end else begin
      if (strobes.wrStep)  wrCnt  <= wrCnt + 1'b1;
      if (strobes.rdAStep) rdCntA <= rdCntA + 1'b1;
      if (strobes.rdBStep) rdCntB <= rdCntB + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                            regs[g] <= '0;
      else if (strobes.wrStep && wrCnt == ADDR_W'(g))     regs[g] <= wrData;
    end

    // R4/R6: the addressed entry holds count+1 on the next cycle
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
      (strobes.wrStep && wrCnt == ADDR_W'(g)) |=> (regs[g] == DATA_W'(g + 1)));
    // R4: other entries keep their value
    assert_write_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !(strobes.wrStep && wrCnt == ADDR_W'(g)) |=> $stable(regs[g]));
  end

  assign portVal[0] = regs[rdCntA];
  assign portVal[1] = regs[rdCntB];

  for (genvar p = 0; p < 2; p++) begin : g_seg
    pb_hex_seg u_seg (
      .nibble(portVal[p]),
      .segN  (segVal[p])
    );
  end

  assign wrAddr  = wrCnt;
  assign rdAddrA = rdCntA;
  assign rdAddrB = rdCntB;
  assign portA   = portVal[0];
  assign portB   = portVal[1];
  assign segA    = segVal[0];
  assign segB    = segVal[1];
  assign segDisp = dispSel ? segVal[1] : segVal[0];

  // R4: the write count advances by one per step, wrapping modulo 4
  assert_wr_step_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.wrStep |=> wrCnt == $past(wrCnt) + 1'b1);
  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !strobes.wrStep |=> $stable(wrCnt));
  // R5: each read counter moves only on its own strobe
  assert_rda_step_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.rdAStep |=> rdCntA == $past(rdCntA) + 1'b1);
  assert_rda_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !strobes.rdAStep |=> $stable(rdCntA));
  assert_rdb_step_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.rdBStep |=> rdCntB == $past(rdCntB) + 1'b1);
  assert_rdb_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !strobes.rdBStep |=> $stable(rdCntB));
  // R1: reset leaves every counter at zero
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (wrCnt == '0 && rdCntA == '0 && rdCntB == '0));
endmodule

// File: rtl/pb_regfile_exerciser.sv
module pb_regfile_exerciser
  import pb_exer_pkg::*;
#(
  parameter int STABLE_LEN  = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btnWrite,
  input  logic       btnReadA,
  input  logic       btnReadB,
  input  logic       dispSel,
  output logic [1:0] wrAddr,
  output logic [1:0] rdAddrA,
  output logic [1:0] rdAddrB,
  output logic [3:0] portA,
  output logic [3:0] portB,
  output logic [6:0] segA,
  output logic [6:0] segB,
  output logic [6:0] segDisp
);
  stepStrobes_t strobes;

  pb_step_control #(
    .STABLE_LEN (STABLE_LEN),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .btnWrite(btnWrite),
    .btnReadA(btnReadA),
    .btnReadB(btnReadB),
    .strobes (strobes)
  );

  pb_regfile_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .dispSel(dispSel),
    .wrAddr (wrAddr),
    .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB),
    .portA  (portA),
    .portB  (portB),
    .segA   (segA),
    .segB   (segB),
    .segDisp(segDisp)
  );
endmodule

// File: tb/pb_regfile_exerciser_bench.sv
`timescale 1ns/1ps
module pb_regfile_exerciser_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnWrite = 1'b0, btnReadA = 1'b0, btnReadB = 1'b0, dispSel = 1'b0;
  logic [1:0] wrAddr, rdAddrA, rdAddrB;
  logic [3:0] portA, portB;
  logic [6:0] segA, segB, segDisp;

  always #10 clk = ~clk;

  pb_regfile_exerciser #(.STABLE_LEN(4), .SYNC_STAGES(2)) u_pb_regfile_exerciser (
    .clk(clk), .rst(rst), .btnWrite(btnWrite), .btnReadA(btnReadA),
    .btnReadB(btnReadB), .dispSel(dispSel), .wrAddr(wrAddr), .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB), .portA(portA), .portB(portB), .segA(segA), .segB(segB),
    .segDisp(segDisp));

  typedef struct {
    string tag;
    int    sel;
    int    exp;
  } item_t;

  item_t sb[$];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  int mdlWr = 0, mdlRdA = 0, mdlRdB = 0;
  int mdlMem[4] = '{0, 0, 0, 0};

  function automatic int segCode(int v);
    case (v)
      0: return 7'b0000001;
      1: return 7'b1001111;
      2: return 7'b0010010;
      3: return 7'b0000110;
      4: return 7'b1001100;
      default: return -1;
    endcase
  endfunction

  function automatic int actualOf(int sel);
    case (sel)
      0: return int'(wrAddr);
      1: return int'(rdAddrA);
      2: return int'(rdAddrB);
      3: return int'(portA);
      4: return int'(portB);
      5: return int'(segA);
      6: return int'(segB);
      default: return int'(segDisp);
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        int act;
        it = sb.pop_front();
        act = actualOf(it.sel);
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s output#%0d actual=%0h expected=%0h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic push(string tag, int sel, int exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic expectAll(string tag);
    int a, b;
    @(posedge clk);
    a = mdlMem[mdlRdA];
    b = mdlMem[mdlRdB];
    push(tag, 0, mdlWr);
    push(tag, 1, mdlRdA);
    push(tag, 2, mdlRdB);
    push(tag, 3, a);
    push(tag, 4, b);
    push(tag, 5, segCode(a));
    push(tag, 6, segCode(b));
    push("R8", 7, dispSel ? segCode(b) : segCode(a));
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setBtn(int which, logic v);
    case (which)
      0: btnWrite = v;
      1: btnReadA = v;
      default: btnReadB = v;
    endcase
  endtask

  task automatic press(int which, int hold);
    @(negedge clk);
    setBtn(which, 1'b1);
    repeat (hold) @(negedge clk);
    setBtn(which, 1'b0);
    repeat (20) @(negedge clk);
    case (which)
      0: begin mdlMem[mdlWr] = mdlWr + 1; mdlWr = (mdlWr + 1) % 4; end
      1: mdlRdA = (mdlRdA + 1) % 4;
      default: mdlRdB = (mdlRdB + 1) % 4;
    endcase
  endtask

  // levels of 2 cycles, shorter than the filter length: no step expected
  task automatic bounce(int which);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      setBtn(which, 1'b1);
      @(negedge clk);
      @(negedge clk);
      setBtn(which, 1'b0);
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    expectAll("R1");

    // R4: full write round, pattern count+1
    for (int i = 0; i < 4; i++) begin
      press(0, 10);
      expectAll("R4");
    end

    // R5/R6/R7: port A sequence 1,2,3,0
    for (int i = 0; i < 4; i++) begin
      press(1, 10);
      expectAll("R5");
    end

    // R5: port B independent of A
    press(2, 10);
    expectAll("R5");
    press(2, 10);
    expectAll("R6");
    press(1, 10);
    expectAll("R7");

    // R8: shared display from port B then A
    @(negedge clk);
    dispSel = 1'b1;
    expectAll("R8");
    @(negedge clk);
    dispSel = 1'b0;
    expectAll("R8");

    // R2: bouncing buttons give no steps
    bounce(0);
    expectAll("R2");
    bounce(1);
    bounce(2);
    expectAll("R2");

    // R3: long holds give one step each
    press(1, 60);
    expectAll("R3");
    press(0, 60);
    expectAll("R3");

    // R4: wrap of write count back to address 0 after more writes
    for (int i = 0; i < 3; i++) press(0, 10);
    expectAll("R4");

    // R1: reset again clears all state
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mdlWr = 0; mdlRdA = 0; mdlRdB = 0;
    for (int i = 0; i < 4; i++) mdlMem[i] = 0;
    expectAll("R1");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule